// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational arithmetic-logic unit for a 32-bit integer datapath. It takes two operands and a 3-bit operation code. It returns a result word, a carry flag and an overflow flag. Six operations are available: two additions, two subtractions, bitwise AND and bitwise OR. One addition and one subtraction are signed; the other two are unsigned.

The datapath is a chain of identical one-bit slices. Each slice holds three parts: a logic unit, a full adder, and a selector that picks the output of one of them. The carry ripples from each slice into the next. A subtraction uses the same adders: every slice inverts its B bit through an XOR gate, and the first slice gets a carry-in of 1.

Overflow is the XOR of the carry entering the top slice and the carry leaving it. The flag is reported only for the two signed operations. Any sign or zero extension of immediate operands must be done before the operands reach this block.

Top module: `bitslice_alu`

## Requirements
- R1: With op = 000 (signed add), r equals (a + b) mod 2^32, and carry equals bit 32 of the unsigned 33-bit sum.
- R2: With op = 001 (unsigned add), r and carry are the same as for op = 000, and ovf is 0.
- R3: With op = 010 (signed subtract), r equals (a - b) mod 2^32. Carry is 1 exactly when a >= b as unsigned numbers, so a carry of 1 means no borrow occurred.
- R4: With op = 011 (unsigned subtract), r and carry are the same as for op = 010, and ovf is 0.
- R5: With op = 100, r equals a AND b, and carry and ovf are both 0.
- R6: With op = 101, r equals a OR b, and carry and ovf are both 0.
- R7: With op = 000, ovf is 1 exactly when a[31] equals b[31] and r[31] differs from a[31].
- R8: With op = 010, ovf is 1 exactly when a[31] differs from b[31] and r[31] differs from a[31].
- R9: With op = 110 or op = 111, r is 0 and carry and ovf are both 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand; it is the subtrahend in a subtraction |
| op | input | 3 | Operation code |
| r | output | 32 | Result word |
| carry | output | 1 | Carry out of the top slice; it is 0 for the logic operations |
| ovf | output | 1 | Two's-complement overflow; it is 0 except for the signed operations |

## Verification
The checker watches the ports whenever they settle and enforces several rules:
- Logic operations and unused codes keep both flags at 0, and unused codes also give a zero result.
- Unsigned operations never raise overflow.
- An OR result always contains every set bit of a.
- The unsigned-subtract carry matches an a >= b comparison.
- A signed-add overflow only ever comes with two operands of equal sign.

Some things only the bench scenarios can show: that the sums and differences are exact, and that the carry out of each slice reaches the next one. These are checked with directed corner cases such as 0x7FFFFFFF + 1, 0x80000000 - 1 and 0 - 0, and with randomised operands compared against an arithmetic reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'b000,
        OP_ADDU = 3'b001,
        OP_SUB  = 3'b010,
        OP_SUBU = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101
    } op_e;

    typedef enum logic [1:0] {
        SEL_ARITH = 2'b00,
        SEL_AND   = 2'b01,
        SEL_OR    = 2'b10,
        SEL_ZERO  = 2'b11
    } sel_e;

    typedef struct packed {
        logic invert_b;
        logic carry_in0;
        sel_e sel;
        logic carry_en;
        logic ovf_en;
    } alu_ctrl_t;

    // Pick one slice output according to the function selector.
    function automatic logic pick_bit(input sel_e sel, input logic s_arith,
                                      input logic s_and, input logic s_or);
        logic y;
        case (sel)
            SEL_ARITH: y = s_arith;
            SEL_AND:   y = s_and;
            SEL_OR:    y = s_or;
            default:   y = 1'b0;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output alu_ctrl_t       ctrl
);
    always_comb begin
        ctrl = '{invert_b: 1'b0, carry_in0: 1'b0, sel: SEL_ZERO,
                 carry_en: 1'b0, ovf_en: 1'b0};
        case (op)
            OP_ADD: begin
                ctrl.sel      = SEL_ARITH;
                ctrl.carry_en = 1'b1;
                ctrl.ovf_en   = 1'b1;
            end
            OP_ADDU: begin
                ctrl.sel      = SEL_ARITH;
                ctrl.carry_en = 1'b1;
            end
            OP_SUB: begin
                ctrl.sel       = SEL_ARITH;
                ctrl.invert_b  = 1'b1;
                ctrl.carry_in0 = 1'b1;
                ctrl.carry_en  = 1'b1;
                ctrl.ovf_en    = 1'b1;
            end
            OP_SUBU: begin
                ctrl.sel       = SEL_ARITH;
                ctrl.invert_b  = 1'b1;
                ctrl.carry_in0 = 1'b1;
                ctrl.carry_en  = 1'b1;
            end
            OP_AND:  ctrl.sel = SEL_AND;
            OP_OR:   ctrl.sel = SEL_OR;
            default: ctrl.sel = SEL_ZERO;
        endcase
    end
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ ci;
    assign co = (x & ci) | (y & ci) | (x & y);
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic cin,
    input  logic invert_b,
    input  sel_e sel,
    output logic r_o,
    output logic cout
);
    logic b_eff;
    logic and_bit;
    logic or_bit;
    logic sum_bit;

    assign b_eff   = b_i ^ invert_b;
    assign and_bit = a_i & b_i;
    assign or_bit  = a_i | b_i;

    alu_full_adder u_fa (
        .x  (a_i),
        .y  (b_eff),
        .ci (cin),
        .s  (sum_bit),
        .co (cout)
    );

    assign r_o = pick_bit(sel, sum_bit, and_bit, or_bit);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    r,
    output logic            carry,
    output logic            ovf
);
    localparam int MSB = W - 1;

    alu_ctrl_t    ctrl;
    logic [W:0]   chain;

    alu_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    assign chain[0] = ctrl.carry_in0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_slice u_slice (
            .a_i      (a[i]),
            .b_i      (b[i]),
            .cin      (chain[i]),
            .invert_b (ctrl.invert_b),
            .sel      (ctrl.sel),
            .r_o      (r[i]),
            .cout     (chain[i+1])
        );
    end

    assign carry = ctrl.carry_en & chain[W];
    assign ovf   = ctrl.ovf_en & (chain[MSB] ^ chain[W]);
endmodule

// File: rtl/alu_checker.sv
module alu_checker
    import alu_pkg::*;
(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] r,
    input logic              carry,
    input logic              ovf
);
    always_comb begin
        if (op == OP_AND || op == OP_OR)
            AST_LOGIC_FLAGS_ZERO: assert (!carry && !ovf);             // R5
        if (op == OP_OR)
            AST_OR_HOLDS_A: assert ((r & a) == a);                     // R6
        if (op == OP_ADDU || op == OP_SUBU)
            AST_UNSIGNED_NO_OVF: assert (!ovf);                        // R2
        if (op == OP_SUBU)
            AST_SUBU_NO_BORROW: assert (carry == (a >= b));            // R4
        if (op == 3'b110 || op == 3'b111)
            AST_UNUSED_CODE_ZERO: assert (r == '0 && !carry && !ovf);  // R9
        if (op == OP_ADD && ovf)
            AST_ADD_OVF_SAME_SIGN: assert (a[DATA_W-1] == b[DATA_W-1]); // R7
    end
endmodule

bind bitslice_alu alu_checker u_chk (
    .a     (a),
    .b     (b),
    .op    (op),
    .r     (r),
    .carry (carry),
    .ovf   (ovf)
);

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [2:0]   op  = 3'b000;
    logic [W-1:0] r;
    logic         carry;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bitslice_alu dut (
        .a     (a),
        .b     (b),
        .op    (op),
        .r     (r),
        .carry (carry),
        .ovf   (ovf)
    );

    // Reference model built from the requirements.
    task automatic expect_of(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                             output logic [W-1:0] er, output logic ec, output logic eo);
        logic [W:0] t;
        er = '0; ec = 1'b0; eo = 1'b0;
        case (o)
            3'b000, 3'b001: begin
                t  = {1'b0, x} + {1'b0, y};
                er = t[W-1:0];
                ec = t[W];
                eo = (o == 3'b000) && (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
            end
            3'b010, 3'b011: begin
                er = x - y;
                ec = (x >= y);
                eo = (o == 3'b010) && (x[W-1] != y[W-1]) && (er[W-1] != x[W-1]);
            end
            3'b100: er = x & y;
            3'b101: er = x | y;
            default: ;
        endcase
    endtask

    task automatic apply_check(input string tag, input logic [2:0] o,
                               input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] er;
        logic ec, eo;
        @(negedge clk);
        op = o; a = x; b = y;
        @(posedge clk);
        #1;
        expect_of(o, x, y, er, ec, eo);
        checks++;
        if (r !== er || carry !== ec || ovf !== eo) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: got r=%h c=%b v=%b, expected r=%h c=%b v=%b",
                     tag, o, x, y, r, carry, ovf, er, ec, eo);
        end
    endtask

    task automatic t_reset_state();
        // Operands all zero after reset with op 000: zero result and no flags (R1).
        apply_check("R1", 3'b000, '0, '0);
    endtask

    task automatic t_add();
        apply_check("R1", 3'b000, 32'h0000_0005, 32'h0000_0003);
        apply_check("R1", 3'b000, 32'hFFFF_FFFF, 32'h0000_0001);
        apply_check("R2", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply_check("R2", 3'b001, 32'h7FFF_FFFF, 32'h0000_0001);
    endtask

    task automatic t_sub();
        apply_check("R3", 3'b010, '0, '0);
        apply_check("R3", 3'b010, 32'h0000_0001, 32'h0000_0002);
        apply_check("R4", 3'b011, 32'h0000_0010, 32'h0000_0010);
        apply_check("R4", 3'b011, 32'h8000_0000, 32'h0000_0001);
    endtask

    task automatic t_logic();
        apply_check("R5", 3'b100, 32'hF0F0_A5A5, 32'hFF00_0FF0);
        apply_check("R5", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply_check("R6", 3'b101, 32'hF0F0_0000, 32'h0000_0F0F);
        apply_check("R6", 3'b101, '0, '0);
    endtask

    task automatic t_overflow();
        apply_check("R7", 3'b000, 32'h7FFF_FFFF, 32'h0000_0001);
        apply_check("R7", 3'b000, 32'h8000_0000, 32'h8000_0000);
        apply_check("R7", 3'b000, 32'h7FFF_FFFF, 32'h8000_0000);
        apply_check("R8", 3'b010, 32'h8000_0000, 32'h0000_0001);
        apply_check("R8", 3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply_check("R8", 3'b010, 32'h0000_0000, 32'h8000_0000);
    endtask

    task automatic t_unused_codes();
        apply_check("R9", 3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply_check("R9", 3'b111, 32'h7FFF_FFFF, 32'h0000_0001);
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            string tag;
            case (o)
                3'b000: tag = "R1";
                3'b001: tag = "R2";
                3'b010: tag = "R3";
                3'b011: tag = "R4";
                3'b100: tag = "R5";
                3'b101: tag = "R6";
                default: tag = "R9";
            endcase
            apply_check(tag, o, $urandom(), $urandom());
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_add();
        t_sub();
        t_logic();
        t_overflow();
        t_unused_codes();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule